// File: doc/BRIEF.md
# Processor status and window-control registers

This unit holds the control registers of a soft processor core that uses register windows. The core reads the registers combinationally through an address and data port, and writes them with a single-cycle write strobe. Besides plain storage, the unit owns the current window pointer (CWP): it moves the pointer down on a save request and up on a restore request. It refuses any move that would leave the window range that software programmed into the window-limit register.

A refused move leaves the pointer where it was. When exception support is built in and interrupts are enabled, it also raises a one-cycle overflow or underflow pulse, which the core's trap logic consumes. When the core takes an exception, the unit copies the status word into the saved-status register and clears the interrupt enable. A return-from-exception request copies the saved word back. Two data-less addresses act as strobes that clear and set the interrupt enable.

Top module: `proc_ctl_regs`

## Requirements
- R1: After reset, STATUS reads with CWP (bits 8:4) equal to the reset high limit and all other bits zero. ISTATUS reads zero. The window-limit register (address 2) reads the reset high limit in bits 12:8 and the reset low limit in bits 4:0.
- R2: STATUS (address 0) stores the flags in bits 3:0, CWP in 8:4, interrupt priority in 14:9, IE in 15, data-cache enable in 16 and instruction-cache enable in 17. Bits 31:18 read zero. A write is visible from the next clock edge.
- R3: A save request lowers CWP by one and a restore request raises it by one. When both requests arrive in the same cycle, only the save acts.
- R4: A save while CWP is at or below the low limit leaves CWP unchanged. If exception support is built in and IE is set, win_ovf_o goes high for exactly one cycle.
- R5: A restore while CWP is at or above the high limit leaves CWP unchanged. If exception support is built in and IE is set, win_unf_o goes high for exactly one cycle.
- R6: While IE is clear, a refused move raises no pulse, and CWP still stays unchanged.
- R7: Any write to address 9 sets IE and any write to address 8 clears IE, whatever the data. Both addresses read zero.
- R8: exc_take_i copies STATUS into ISTATUS (address 1) and clears IE in STATUS on the same edge.
- R9: rte_i copies ISTATUS back into STATUS.
- R10: Addresses 3 to 7 and 10 to 15 read zero, and writes to them change no register. The window-limit register keeps only bits 12:8 and 4:0 of a write.
- R11: Priority runs from exc_take_i, through rte_i, then a register write, down to a window move. A write is dropped during exc_take_i or rte_i, and a window move is dropped in any cycle that carries a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| addr_i | input | 4 | Control register address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| save_i | input | 1 | Window save request (CWP down) |
| restore_i | input | 1 | Window restore request (CWP up) |
| exc_take_i | input | 1 | Core is taking an exception |
| rte_i | input | 1 | Return from exception |
| cwp_o | output | 5 | Current window pointer |
| ie_o | output | 1 | Interrupt enable |
| win_ovf_o | output | 1 | One-cycle pulse on a refused save |
| win_unf_o | output | 1 | One-cycle pulse on a refused restore |

## Verification
The assertions check the following relations on every cycle:
- an overflow or underflow pulse only ever follows a cycle in which IE was set and CWP did not move;
- a written cycle never produces a pulse;
- taking an exception always leaves the old status in ISTATUS with IE cleared;
- a return always restores the saved word;
- the IE strobes always land.

Only the bench scenarios can show the rest:
- the exact pointer values along a walk from the high limit down to the low limit and back;
- the save-wins rule when both requests arrive together;
- the one-cycle length of a pulse;
- the read-back layouts of STATUS and the window-limit register;
- the silence of unused addresses;
- the effect of reprogramming the limits.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int FLAG_W = 4;
  localparam int CWP_W  = 5;
  localparam int IPRI_W = 6;
  localparam int ST_W   = FLAG_W + CWP_W + IPRI_W + 3;
  localparam int WV_HI_LSB = 8;

  typedef struct packed {
    logic              ic;
    logic              dc;
    logic              ie;
    logic [IPRI_W-1:0] ipri;
    logic [CWP_W-1:0]  cwp;
    logic [FLAG_W-1:0] flags;
  } status_t;

  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd0;
  localparam logic [ADDR_W-1:0] A_ISTATUS = 4'd1;
  localparam logic [ADDR_W-1:0] A_WLIMIT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_IE_CLR  = 4'd8;
  localparam logic [ADDR_W-1:0] A_IE_SET  = 4'd9;
endpackage

// File: rtl/ctl_wnd.sv
module ctl_wnd
  import ctl_pkg::*;
#(
  parameter bit EXC_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             ie_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] lo_i,
  input  logic [CWP_W-1:0] hi_i,
  output logic             mv_o,
  output logic [CWP_W-1:0] cwp_nxt_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic fault_en;
  logic ovf_d, unf_d;
  logic save_ok, rest_ok;

  generate
    if (EXC_EN) begin : g_exc
      assign fault_en = ie_i;
    end else begin : g_noexc
      assign fault_en = 1'b0;
    end
  endgenerate

  assign save_ok = cwp_i > lo_i;
  assign rest_ok = cwp_i < hi_i;

  always_comb begin
    mv_o      = 1'b0;
    cwp_nxt_o = cwp_i;
    ovf_d     = 1'b0;
    unf_d     = 1'b0;
    if (eval_i) begin
      if (save_i) begin
        if (save_ok) begin
          mv_o      = 1'b1;
          cwp_nxt_o = cwp_i - 1'b1;
        end else begin
          ovf_d = fault_en;
        end
      end else if (restore_i) begin
        if (rest_ok) begin
          mv_o      = 1'b1;
          cwp_nxt_o = cwp_i + 1'b1;
        end else begin
          unf_d = fault_en;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= ovf_d;
      unf_o <= unf_d;
    end
  end

  // R4 R5
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
endmodule

// File: rtl/ctl_status.sv
module ctl_status
  import ctl_pkg::*;
#(
  parameter logic [CWP_W-1:0] RST_CWP = 5'd7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_take_i,
  input  logic             rte_i,
  input  logic             wr_st_i,
  input  logic             wr_ist_i,
  input  logic             ie_clr_i,
  input  logic             ie_set_i,
  input  logic [ST_W-1:0]  wdata_i,
  input  logic             mv_i,
  input  logic [CWP_W-1:0] cwp_nxt_i,
  output status_t          status_o,
  output status_t          istatus_o
);
  status_t status_q, istatus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q     <= '0;
      status_q.cwp <= RST_CWP;
      istatus_q    <= '0;
    end else if (exc_take_i) begin
      istatus_q   <= status_q;
      status_q.ie <= 1'b0;
    end else if (rte_i) begin
      status_q <= istatus_q;
    end else if (wr_st_i) begin
      status_q <= status_t'(wdata_i);
    end else if (wr_ist_i) begin
      istatus_q <= status_t'(wdata_i);
    end else if (ie_clr_i) begin
      status_q.ie <= 1'b0;
    end else if (ie_set_i) begin
      status_q.ie <= 1'b1;
    end else if (mv_i) begin
      status_q.cwp <= cwp_nxt_i;
    end
  end

  assign status_o  = status_q;
  assign istatus_o = istatus_q;

  // R8
  exc_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_i |=> (istatus_q == $past(status_q)) && !status_q.ie);
  // R9
  rte_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rte_i && !exc_take_i |=> status_q == $past(istatus_q));
  // R7
  ie_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_set_i && !exc_take_i && !rte_i |=> status_q.ie);
  // R7
  ie_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_clr_i |=> !status_q.ie);
endmodule

// File: rtl/ctl_rdmux.sv
module ctl_rdmux
  import ctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  status_t           status_i,
  input  status_t           istatus_i,
  input  logic [CWP_W-1:0]  lo_i,
  input  logic [CWP_W-1:0]  hi_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] wlim;

  always_comb begin
    wlim = '0;
    wlim[WV_HI_LSB +: CWP_W] = hi_i;
    wlim[CWP_W-1:0]          = lo_i;
  end

  always_comb begin
    unique case (addr_i)
      A_STATUS:  rdata_o = DATA_W'(status_i);
      A_ISTATUS: rdata_o = DATA_W'(istatus_i);
      A_WLIMIT:  rdata_o = wlim;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/proc_ctl_regs.sv
module proc_ctl_regs
  import ctl_pkg::*;
#(
  parameter bit               EXC_EN = 1'b1,
  parameter logic [CWP_W-1:0] RST_HI = 5'd7,
  parameter logic [CWP_W-1:0] RST_LO = 5'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic              exc_take_i,
  input  logic              rte_i,
  output logic [CWP_W-1:0]  cwp_o,
  output logic              ie_o,
  output logic              win_ovf_o,
  output logic              win_unf_o
);
  status_t          status, istatus;
  logic [CWP_W-1:0] lo_q, hi_q, cwp_nxt;
  logic             wr_ok, eval, mv;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:ST_W];

  assign wr_ok = wr_en_i && !exc_take_i && !rte_i;
  assign eval  = !exc_take_i && !rte_i && !wr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= RST_LO;
      hi_q <= RST_HI;
    end else if (wr_ok && addr_i == A_WLIMIT) begin
      lo_q <= wdata_i[CWP_W-1:0];
      hi_q <= wdata_i[WV_HI_LSB +: CWP_W];
    end
  end

  ctl_wnd #(.EXC_EN(EXC_EN)) u_wnd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eval_i    (eval),
    .save_i    (save_i),
    .restore_i (restore_i),
    .ie_i      (status.ie),
    .cwp_i     (status.cwp),
    .lo_i      (lo_q),
    .hi_i      (hi_q),
    .mv_o      (mv),
    .cwp_nxt_o (cwp_nxt),
    .ovf_o     (win_ovf_o),
    .unf_o     (win_unf_o)
  );

  ctl_status #(.RST_CWP(RST_HI)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exc_take_i (exc_take_i),
    .rte_i      (rte_i),
    .wr_st_i    (wr_ok && addr_i == A_STATUS),
    .wr_ist_i   (wr_ok && addr_i == A_ISTATUS),
    .ie_clr_i   (wr_ok && addr_i == A_IE_CLR),
    .ie_set_i   (wr_ok && addr_i == A_IE_SET),
    .wdata_i    (wdata_i[ST_W-1:0]),
    .mv_i       (mv),
    .cwp_nxt_i  (cwp_nxt),
    .status_o   (status),
    .istatus_o  (istatus)
  );

  ctl_rdmux u_rdmux (
    .addr_i    (addr_i),
    .status_i  (status),
    .istatus_i (istatus),
    .lo_i      (lo_q),
    .hi_i      (hi_q),
    .rdata_o   (rdata_o)
  );

  assign cwp_o = status.cwp;
  assign ie_o  = status.ie;

  // R4
  ovf_cwp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_ovf_o |-> $stable(cwp_o));
  // R5
  unf_cwp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_unf_o |-> $stable(cwp_o));
  // R6
  pulse_needs_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_ovf_o || win_unf_o) |-> $past(ie_o));
  // R11
  wr_blocks_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !win_ovf_o && !win_unf_o);
endmodule

// File: tb/proc_ctl_regs_test.sv
`timescale 1ns/1ps
module proc_ctl_regs_test;
  localparam int K_RD = 0, K_CWP = 1, K_IE = 2, K_OVF = 3, K_UNF = 4;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        save = 1'b0, restore = 1'b0, exc_take = 1'b0, rte = 1'b0;
  logic [31:0] rdata;
  logic [4:0]  cwp;
  logic        ie, ovf, unf;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  proc_ctl_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .save_i(save), .restore_i(restore),
    .exc_take_i(exc_take), .rte_i(rte), .cwp_o(cwp), .ie_o(ie),
    .win_ovf_o(ovf), .win_unf_o(unf)
  );

  task automatic drive(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic sv, input logic rs, input logic ex, input logic rt);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; save = sv; restore = rs; exc_take = ex; rte = rt;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic look(input logic [3:0] a);
    drive(1'b0, a, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic expect_v(input int k, input logic [31:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  // monitor: compares after the driver's inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = rdata;
          K_CWP:   act = {27'd0, cwp};
          K_IE:    act = {31'd0, ie};
          K_OVF:   act = {31'd0, ovf};
          default: act = {31'd0, unf};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #250000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    look(4'd0); expect_v(K_RD, 32'h70, "R1 status"); expect_v(K_CWP, 7, "R1 cwp");
    expect_v(K_IE, 0, "R1 ie");
    look(4'd1); expect_v(K_RD, 0, "R1 istatus");
    look(4'd2); expect_v(K_RD, 32'h0701, "R1 wlimit");

    // R7 set IE
    wr(4'd9, 32'h0);
    look(4'd9); expect_v(K_RD, 0, "R7 addr9 reads 0"); expect_v(K_IE, 1, "R7 set");
    look(4'd0); expect_v(K_RD, 32'h8070, "R2 status ie bit15");

    // R5 restore at high limit
    drive(1'b0, 4'd0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    look(4'd0); expect_v(K_UNF, 1, "R5 unf pulse"); expect_v(K_CWP, 7, "R5 cwp hold");
    look(4'd0); expect_v(K_UNF, 0, "R5 single cycle");

    // R3 walk down
    for (int i = 1; i <= 6; i++) begin
      drive(1'b0, 4'd0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
      look(4'd0); expect_v(K_CWP, 7 - i, "R3 save step");
    end

    // R4 save at low limit
    drive(1'b0, 4'd0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    look(4'd0); expect_v(K_OVF, 1, "R4 ovf pulse"); expect_v(K_CWP, 1, "R4 cwp hold");
    look(4'd0); expect_v(K_OVF, 0, "R4 single cycle");

    drive(1'b0, 4'd0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    look(4'd0); expect_v(K_CWP, 2, "R3 restore step");

    // R7 clear IE with nonzero data
    wr(4'd8, 32'hFFFF_FFFF);
    look(4'd8); expect_v(K_IE, 0, "R7 clear"); expect_v(K_RD, 0, "R7 addr8 reads 0");

    // R6 refused move without IE
    drive(1'b0, 4'd0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 4'd0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    look(4'd0); expect_v(K_OVF, 0, "R6 no pulse"); expect_v(K_CWP, 1, "R6 cwp hold");

    // R3 save wins over restore
    drive(1'b0, 4'd0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 4'd0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    look(4'd0); expect_v(K_CWP, 1, "R3 save priority");

    // R2 layout and masking
    wr(4'd0, 32'hFFFF_FFFF);
    look(4'd0); expect_v(K_RD, 32'h3FFFF, "R2 upper bits zero");
    wr(4'd0, 32'h28A3A);
    look(4'd0); expect_v(K_RD, 32'h28A3A, "R2 write");
    expect_v(K_CWP, 3, "R2 cwp field"); expect_v(K_IE, 1, "R2 ie field");

    // R8 exception save
    drive(1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    look(4'd1); expect_v(K_RD, 32'h28A3A, "R8 istatus"); expect_v(K_IE, 0, "R8 ie cleared");
    look(4'd0); expect_v(K_RD, 32'h20A3A, "R8 status");

    // R9 return
    wr(4'd0, 32'h75);
    drive(1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    look(4'd0); expect_v(K_RD, 32'h28A3A, "R9 restored"); expect_v(K_IE, 1, "R9 ie");

    // R11 exception beats write
    drive(1'b1, 4'd0, 32'h5, 1'b0, 1'b0, 1'b1, 1'b0);
    look(4'd0); expect_v(K_RD, 32'h20A3A, "R11 write dropped");
    // R11 write suppresses move
    drive(1'b1, 4'd2, 32'h0502, 1'b1, 1'b0, 1'b0, 1'b0);
    look(4'd2); expect_v(K_RD, 32'h0502, "R10 wlimit write"); expect_v(K_CWP, 3, "R11 move dropped");

    // R10 masking and unused addresses
    wr(4'd2, 32'hFFFF_FFFF);
    look(4'd2); expect_v(K_RD, 32'h1F1F, "R10 wlimit mask");
    wr(4'd5, 32'hDEAD_BEEF);
    look(4'd5); expect_v(K_RD, 0, "R10 addr5");
    look(4'd15); expect_v(K_RD, 0, "R10 addr15");
    look(4'd0); expect_v(K_RD, 32'h20A3A, "R10 status untouched");

    // R4 R5 with reprogrammed limits lo=2 hi=5
    wr(4'd2, 32'h0502);
    wr(4'd9, 32'h0);
    drive(1'b0, 4'd0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 4'd0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    look(4'd0); expect_v(K_OVF, 1, "R4 new lo"); expect_v(K_CWP, 2, "R4 new lo cwp");
    for (int i = 0; i < 3; i++)
      drive(1'b0, 4'd0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 4'd0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    look(4'd0); expect_v(K_UNF, 1, "R5 new hi"); expect_v(K_CWP, 5, "R5 new hi cwp");

    look(4'd0);
    look(4'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule